// File: doc/BRIEF.md
# Serial Clock Pulse Count Write Guard

This block sits beside the command controller of a three-wire serial EEPROM and keeps a noisy serial clock from corrupting memory. While the chip-select input is high, it counts the serial clock rising edges of one framed transaction. The edge that samples the start bit counts as pulse one. When chip select falls, the block compares the total against the exact length that the decoded programming instruction needs in the current organisation. An extra glitch edge shifts the address and data by one bit. In that case the totals no longer match, and the execute permit is withheld, so no self-timed cycle starts.

The block receives the system clock, an active-low reset, the chip-select level, a one-cycle strobe for each serial clock rising edge, a one-cycle start-bit pulse from the decoder, the decoded instruction class and the organisation mode. It returns one registered signal, `exec_permit`. This signal is a single-cycle pulse in the cycle after the system clock edge that first sees chip select low. The controller reads it at that point to decide whether to launch a programming cycle. Reads and the enable and disable instructions are never blocked.

The block is controlled by a four-state machine. IDLE is the state with chip select low. HUNT means chip select is high and no start bit has arrived. COUNT means the start bit was seen and edges are being counted. OVER means the counter has reached its ceiling. The transitions are: IDLE to HUNT when select rises without a start pulse. IDLE or HUNT to COUNT on a start pulse while select is high. COUNT to OVER when the counter sits at its ceiling. Any state to IDLE when select is low. Leaving COUNT or OVER this way is the frame end, and the verdict is registered at that edge.

Top module: `ckg_pulse_guard`

## Requirements
- R1: During and after reset, with chip select low, `exec_permit` is 0 and the pulse count is 0.
- R2: Counting starts at the start-bit pulse, which counts as 1 whether or not an edge strobe comes in the same cycle. Each later edge strobe while select is high adds 1. Edge strobes before the start pulse are not counted.
- R3: For instruction classes WRITE (`instr_cls`=4) and WRAL (5) with `org_x16`=0, a permit is given only when the frame count is exactly 20.
- R4: For WRITE (4) and WRAL (5) with `org_x16`=1, a permit is given only when the frame count is exactly 27.
- R5: For ERASE (6) and ERAL (7), a permit is given only when the count is exactly 12 with `org_x16`=0, or exactly 11 with `org_x16`=1.
- R6: Classes NONE (0), READ (1), write-enable (2) and write-disable (3) are not gated. Any frame of these classes that saw a start bit ends with a permit, whatever its count.
- R7: The counter saturates at 28, one above the largest expected count. A frame that is long enough to wrap a 5-bit counter back to an expected value (52 pulses for x8 WRITE) gets no permit.
- R8: `exec_permit` is high for exactly one cycle. That cycle follows the system clock edge at which select is first sampled low after being high. At every other time the signal is 0.
- R9: A frame that ends without a start-bit pulse gives no permit.
- R10: Select low clears the count. Edge strobes while select is low are ignored. A frame that follows a rejected frame is judged only on its own pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Chip-select level, high frames a transaction |
| clk_edge | input | 1 | One-cycle strobe per serial clock rising edge |
| start_pulse | input | 1 | One-cycle pulse when the start bit is recognised |
| instr_cls | input | 3 | Decoded instruction class, valid at select fall |
| org_x16 | input | 1 | Organisation: 1 = 16-bit words, 0 = bytes |
| exec_permit | output | 1 | One-cycle execute permit after a select fall |

## Verification
The verdict is due one system clock edge after chip select is first sampled low. The bench lowers select on a falling clock edge, waits for exactly one rising edge, and reads `exec_permit` at the following falling edge. It reads the signal again one cycle later to confirm that the pulse has ended. Edge strobes and start pulses are driven on falling edges and last one cycle, so each one is counted at a single known rising edge. The frame length is therefore set directly by the number of strobes the bench issues.

// File: rtl/ckg_pkg.sv
package ckg_pkg;

    typedef enum logic [2:0] {
        CLS_NONE  = 3'd0,
        CLS_READ  = 3'd1,
        CLS_WEN   = 3'd2,
        CLS_WDS   = 3'd3,
        CLS_WRITE = 3'd4,
        CLS_WRAL  = 3'd5,
        CLS_ERASE = 3'd6,
        CLS_ERAL  = 3'd7
    } instr_cls_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HUNT  = 2'd1,
        ST_COUNT = 2'd2,
        ST_OVER  = 2'd3
    } guard_state_e;

    // Programming classes occupy the upper half of the class code.
    function automatic logic cls_is_gated(input logic [2:0] cls);
        return cls[2];
    endfunction

    // WRITE and WRAL carry a data field after the address.
    function automatic logic cls_has_data(input logic [2:0] cls);
        return cls[2] & ~cls[1];
    endfunction

endpackage

// File: rtl/ckg_edge_counter.sv
module ckg_edge_counter #(
    parameter int CNT_W = 5,
    parameter int CEIL  = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load_one,
    input  logic             step,
    output logic [CNT_W-1:0] cnt,
    output logic             at_ceil
);

    localparam logic [CNT_W-1:0] CEIL_V = CEIL[CNT_W-1:0];
    localparam logic [CNT_W-1:0] ONE_V  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (load_one) begin
            cnt_q <= ONE_V;
        end else if (step && (cnt_q != CEIL_V)) begin
            cnt_q <= cnt_q + ONE_V;
        end
    end

    assign cnt     = cnt_q;
    assign at_ceil = (cnt_q == CEIL_V);

endmodule

// File: rtl/ckg_expect_len.sv
module ckg_expect_len
    import ckg_pkg::*;
#(
    parameter int CNT_W    = 5,
    parameter int OPC_BITS = 2,
    parameter int ADDR_X8  = 9,
    parameter int ADDR_X16 = 8,
    parameter int DATA_X8  = 8,
    parameter int DATA_X16 = 16
) (
    input  logic [2:0]       cls,
    input  logic             org_x16,
    output logic [CNT_W-1:0] exp_len,
    output logic             gated
);

    localparam int HEAD      = 1 + OPC_BITS;
    localparam int ER_X8     = HEAD + ADDR_X8;
    localparam int ER_X16    = HEAD + ADDR_X16;
    localparam int WR_X8     = ER_X8 + DATA_X8;
    localparam int WR_X16    = ER_X16 + DATA_X16;

    localparam logic [CNT_W-1:0] ER_X8_V  = ER_X8[CNT_W-1:0];
    localparam logic [CNT_W-1:0] ER_X16_V = ER_X16[CNT_W-1:0];
    localparam logic [CNT_W-1:0] WR_X8_V  = WR_X8[CNT_W-1:0];
    localparam logic [CNT_W-1:0] WR_X16_V = WR_X16[CNT_W-1:0];

    logic has_data;

    always_comb begin
        gated    = cls_is_gated(cls);
        has_data = cls_has_data(cls);
        unique case ({has_data, org_x16})
            2'b00:   exp_len = ER_X8_V;
            2'b01:   exp_len = ER_X16_V;
            2'b10:   exp_len = WR_X8_V;
            default: exp_len = WR_X16_V;
        endcase
    end

endmodule

// File: rtl/ckg_pulse_guard.sv
module ckg_pulse_guard
    import ckg_pkg::*;
#(
    parameter int OPC_BITS = 2,
    parameter int ADDR_X8  = 9,
    parameter int ADDR_X16 = 8,
    parameter int DATA_X8  = 8,
    parameter int DATA_X16 = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  logic       clk_edge,
    input  logic       start_pulse,
    input  logic [2:0] instr_cls,
    input  logic       org_x16,
    output logic       exec_permit
);

    localparam int LEN_WR_X8  = 1 + OPC_BITS + ADDR_X8 + DATA_X8;
    localparam int LEN_WR_X16 = 1 + OPC_BITS + ADDR_X16 + DATA_X16;
    localparam int MAX_LEN    = (LEN_WR_X8 > LEN_WR_X16) ? LEN_WR_X8 : LEN_WR_X16;
    localparam int CNT_CEIL   = MAX_LEN + 1;
    localparam int CNT_W      = $clog2(CNT_CEIL + 1);

    guard_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] exp_len;
    logic             at_ceil;
    logic             gated;
    logic             cnt_clear, cnt_load, cnt_step;
    logic             frame_end, verdict;
    logic             permit_q;

    ckg_expect_len #(
        .CNT_W    (CNT_W),
        .OPC_BITS (OPC_BITS),
        .ADDR_X8  (ADDR_X8),
        .ADDR_X16 (ADDR_X16),
        .DATA_X8  (DATA_X8),
        .DATA_X16 (DATA_X16)
    ) u_expect (
        .cls     (instr_cls),
        .org_x16 (org_x16),
        .exp_len (exp_len),
        .gated   (gated)
    );

    always_comb begin
        cnt_clear = !sel;
        cnt_load  = sel && start_pulse
                    && ((state_q == ST_IDLE) || (state_q == ST_HUNT));
        cnt_step  = sel && clk_edge && (state_q == ST_COUNT);
    end

    ckg_edge_counter #(
        .CNT_W (CNT_W),
        .CEIL  (CNT_CEIL)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cnt_clear),
        .load_one (cnt_load),
        .step     (cnt_step),
        .cnt      (cnt_q),
        .at_ceil  (at_ceil)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sel) state_d = start_pulse ? ST_COUNT : ST_HUNT;
            end
            ST_HUNT: begin
                if (!sel)             state_d = ST_IDLE;
                else if (start_pulse) state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (!sel)         state_d = ST_IDLE;
                else if (at_ceil) state_d = ST_OVER;
            end
            ST_OVER: begin
                if (!sel) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Verdict at frame end
    always_comb begin
        frame_end = !sel && ((state_q == ST_COUNT) || (state_q == ST_OVER));
        verdict   = !gated || ((state_q == ST_COUNT) && (cnt_q == exp_len));
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) permit_q <= 1'b0;
        else        permit_q <= frame_end && verdict;
    end

    assign exec_permit = permit_q;

endmodule

// File: rtl/ckg_guard_chk.sv
module ckg_guard_chk #(
    parameter int CNT_W    = 5,
    parameter int CNT_CEIL = 28
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel,
    input logic [2:0]       instr_cls,
    input logic             exec_permit,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] exp_len
);

    AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> (cnt == '0)); // R1

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1) || (cnt <= 1))); // R2

    AST_GATED_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_permit && $past(instr_cls[2])) |-> ($past(cnt) == $past(exp_len))); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(CNT_CEIL)); // R7

    AST_PERMIT_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        exec_permit |-> (!$past(sel) && $past(sel, 2))); // R8

    AST_PERMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        exec_permit |=> !exec_permit); // R8

    AST_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (cnt == '0)); // R10

endmodule

bind ckg_pulse_guard ckg_guard_chk #(
    .CNT_W    (CNT_W),
    .CNT_CEIL (CNT_CEIL)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel         (sel),
    .instr_cls   (instr_cls),
    .exec_permit (exec_permit),
    .cnt         (cnt_q),
    .exp_len     (exp_len)
);

// File: tb/tb_ckg_pulse_guard.sv
module tb_ckg_pulse_guard;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0;
    logic       clk_edge = 1'b0;
    logic       start_pulse = 1'b0;
    logic [2:0] instr_cls = 3'd0;
    logic       org_x16 = 1'b0;
    logic       exec_permit;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ckg_pulse_guard dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (sel),
        .clk_edge    (clk_edge),
        .start_pulse (start_pulse),
        .instr_cls   (instr_cls),
        .org_x16     (org_x16),
        .exec_permit (exec_permit)
    );

    // Fields: req[18:15] cls[14:12] org[11] pre[10:7] pulses[6:1] exp[0]
    localparam int NV = 17;
    localparam logic [18:0] VECS [NV] = '{
        {4'd3, 3'd4, 1'b0, 4'd0, 6'd20, 1'b1},  // R3 WRITE x8 exact
        {4'd3, 3'd4, 1'b0, 4'd0, 6'd19, 1'b0},  // R3 one short
        {4'd3, 3'd4, 1'b0, 4'd0, 6'd21, 1'b0},  // R3 one glitch extra
        {4'd3, 3'd5, 1'b0, 4'd0, 6'd20, 1'b1},  // R3 WRAL x8
        {4'd4, 3'd4, 1'b1, 4'd0, 6'd27, 1'b1},  // R4 WRITE x16 exact
        {4'd4, 3'd5, 1'b1, 4'd0, 6'd26, 1'b0},  // R4 WRAL short
        {4'd4, 3'd5, 1'b1, 4'd0, 6'd27, 1'b1},  // R4 WRAL exact
        {4'd4, 3'd4, 1'b1, 4'd0, 6'd20, 1'b0},  // R4 x8 length in x16
        {4'd5, 3'd6, 1'b0, 4'd0, 6'd12, 1'b1},  // R5 ERASE x8
        {4'd5, 3'd6, 1'b1, 4'd0, 6'd11, 1'b1},  // R5 ERASE x16
        {4'd5, 3'd7, 1'b1, 4'd0, 6'd12, 1'b0},  // R5 ERAL x16 extra
        {4'd5, 3'd7, 1'b0, 4'd0, 6'd12, 1'b1},  // R5 ERAL x8
        {4'd6, 3'd1, 1'b0, 4'd0, 6'd35, 1'b1},  // R6 long READ
        {4'd6, 3'd2, 1'b1, 4'd0, 6'd11, 1'b1},  // R6 enable
        {4'd2, 3'd4, 1'b0, 4'd5, 6'd20, 1'b1},  // R2 leading edges
        {4'd2, 3'd6, 1'b1, 4'd3, 6'd11, 1'b1},  // R2 leading edges
        {4'd7, 3'd4, 1'b0, 4'd0, 6'd52, 1'b0}   // R7 wrap-around length
    };

    task automatic check(input bit ok, input int req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_edge(input bit with_start);
        clk_edge    = 1'b1;
        start_pulse = with_start;
        @(negedge clk);
        clk_edge    = 1'b0;
        start_pulse = 1'b0;
        @(negedge clk);
    endtask

    // Frame: pre edges, then start (pulse 1) plus pulses-1 edges, then select fall.
    task automatic run_frame(input logic [2:0] cls, input logic org, input int pre,
                             input int pulses, input bit use_start, input int req,
                             input bit exp_permit);
        @(negedge clk);
        sel = 1'b1; instr_cls = cls; org_x16 = org;
        for (int i = 0; i < pre; i++) pulse_edge(1'b0);
        if (use_start) begin
            pulse_edge(1'b1);
            for (int i = 1; i < pulses; i++) pulse_edge(1'b0);
        end else begin
            for (int i = 0; i < pulses; i++) pulse_edge(1'b0);
        end
        check(exec_permit == 1'b0, 8, exec_permit, 0);   // R8 quiet before fall
        sel = 1'b0;
        @(negedge clk);
        check(exec_permit == exp_permit, req, exec_permit, exp_permit);
        @(negedge clk);
        check(exec_permit == 1'b0, 8, exec_permit, 0);   // R8 single cycle
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(exec_permit == 1'b0, 1, exec_permit, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(exec_permit == 1'b0, 1, exec_permit, 0);

        for (int v = 0; v < NV; v++) begin
            run_frame(VECS[v][14:12], VECS[v][11], int'(VECS[v][10:7]),
                      int'(VECS[v][6:1]), 1'b1, int'(VECS[v][18:15]), VECS[v][0]);
        end

        // R6: unclassified frame is not gated
        run_frame(3'd0, 1'b0, 0, 3, 1'b1, 6, 1'b1);
        // R6: disable instruction, x8 length
        run_frame(3'd3, 1'b0, 0, 12, 1'b1, 6, 1'b1);

        // R9: exact length but no start bit, for a gated and an ungated class
        run_frame(3'd4, 1'b0, 0, 20, 1'b0, 9, 1'b0);
        run_frame(3'd1, 1'b0, 0, 5, 1'b0, 9, 1'b0);

        // R10: strobes while select is low are ignored, no permit appears
        @(negedge clk);
        for (int i = 0; i < 6; i++) pulse_edge(1'b0);
        check(exec_permit == 1'b0, 10, exec_permit, 0);
        // R10: rejected long frame followed by an exact one
        run_frame(3'd4, 1'b0, 0, 25, 1'b1, 10, 1'b0);
        run_frame(3'd4, 1'b0, 0, 20, 1'b1, 10, 1'b1);
        // R10: short frame then exact erase, back to back
        run_frame(3'd6, 1'b1, 0, 4, 1'b1, 10, 1'b0);
        run_frame(3'd6, 1'b1, 0, 11, 1'b1, 10, 1'b1);

        // R2: start pulse in the very cycle select rises (no idle gap)
        @(negedge clk);
        sel = 1'b1; instr_cls = 3'd6; org_x16 = 1'b0;
        pulse_edge(1'b1);
        for (int i = 1; i < 12; i++) pulse_edge(1'b0);
        sel = 1'b0;
        @(negedge clk);
        check(exec_permit == 1'b1, 2, exec_permit, 1);
        @(negedge clk);
        check(exec_permit == 1'b0, 8, exec_permit, 0);

        // R1: reset in mid frame clears the count
        @(negedge clk);
        sel = 1'b1; instr_cls = 3'd6; org_x16 = 1'b1;
        pulse_edge(1'b1);
        for (int i = 0; i < 5; i++) pulse_edge(1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        sel = 1'b0;
        @(negedge clk);
        check(exec_permit == 1'b0, 1, exec_permit, 0);

        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule